// File: doc/BRIEF.md
# Programmable trigger-to-gate generator

This block turns each qualifying edge on an asynchronous trigger line into a single timed gate pulse. All timing is counted in base ticks produced by a prescaler on the system clock. The prescaler divide ratio is chosen so that one tick equals 2.5 µs, for example 100 clocks at 40 MHz. The prescaler restarts when a trigger is accepted, so tick boundaries line up with the trigger instant.

After acceptance the block waits a built-in delay of nine ticks, then a programmable number of extra ticks, and then raises the gate. The gate stays high for a built-in two ticks plus a programmable number of extra ticks. The two programmable counts are 16-bit values held in a two-entry register file, which can be written and read back. A strap input chooses the trigger sense. A busy output covers the whole interval from acceptance until the gate falls. During that interval further triggers are ignored, and register writes do not alter the cycle already in progress.

Top module: `trig_gate_gen`

## Requirements
- R1: After reset, `gate` and `busy` are low and both settings registers read back as 0.
- R2: A write with `reg_wr` high stores `reg_wdata` into the register chosen by `reg_sel` (0 = extra delay, 1 = extra width). `reg_rdata` shows the chosen register combinationally and reflects a write on the next cycle.
- R3: When `trig_in` enters its active level while idle, `busy` rises on the third rising clock edge after that change (two synchroniser stages plus one acceptance stage).
- R4: `gate` rises exactly (9 + D) × TICK_CLKS clock cycles after `busy` rises, where D is the delay setting latched at acceptance.
- R5: `gate` stays high exactly (2 + W) × TICK_CLKS cycles, where W is the width setting latched at acceptance. `busy` falls in the same cycle as `gate`, and `gate` is never high without `busy`.
- R6: With `trig_inv` = 0 the active level of `trig_in` is high, so a rising edge fires. With `trig_inv` = 1 the active level is low, so a falling edge fires. The opposite edge never starts a cycle.
- R7: Trigger edges that arrive while `busy` is high are ignored. They neither shift the current timing nor start a later cycle.
- R8: The settings are captured at acceptance. Writes made during a cycle change only the read-back value and the next cycle's timing.
- R9: A trigger held at its active level after a cycle ends does not start another cycle. Only a fresh edge does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Asynchronous trigger line |
| trig_inv | input | 1 | Trigger sense strap: 0 active high, 1 active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 delay, 1 width |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read-back of the selected register |
| gate | output | 1 | Timed gate pulse |
| busy | output | 1 | High from acceptance until the gate falls |

## Verification
The hardest situation to reach from the ports is a second trigger edge, or a register write, that lands inside an active cycle at a known phase of the delay. The stimulus anchors itself on the observed rise of `busy`. It then releases and reasserts the trigger, or issues writes, a fixed number of cycles later, while the delay counter is still running. The timing is measured against the settings held before the disturbance. A near-exhaustive sweep over small settings under both polarities, with the prescaler shrunk to three clocks, exercises every terminal-count boundary of the counters.

// File: rtl/tgg_pkg.sv
package tgg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_GATE  = 2'd2
  } tgg_state_e;

  localparam int unsigned TGG_NREG   = 2;
  localparam int unsigned TGG_SEL_W  = $clog2(TGG_NREG);
  localparam int unsigned TGG_SEL_DLY = 0;
  localparam int unsigned TGG_SEL_WID = 1;
endpackage

// File: rtl/tgg_trig_edge.sv
module tgg_trig_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  input  logic trig_inv,
  output logic trig_edge
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   act_lvl;
  logic                   lvl_q;
  logic                   primed_q;

  always_comb begin
    sync_d  = {sync_q[SYNC_STAGES-2:0], trig_in};
    act_lvl = sync_q[SYNC_STAGES-1] ^ trig_inv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      lvl_q    <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      sync_q   <= sync_d;
      lvl_q    <= act_lvl;
      primed_q <= 1'b1;
    end
  end

  assign trig_edge = primed_q & act_lvl & ~lvl_q;
endmodule

// File: rtl/tgg_prescaler.sv
module tgg_prescaler #(
  parameter int unsigned TICK_CLKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int unsigned PW = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
  localparam logic [PW-1:0] LIM = PW'(TICK_CLKS - 1);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    tick   = run && (cnt_q == LIM);
    cnt_en = restart || run;
    if (restart || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tgg_regs.sv
module tgg_regs
  import tgg_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [TGG_SEL_W-1:0] reg_sel,
  input  logic [CNT_W-1:0]     reg_wdata,
  output logic [CNT_W-1:0]     reg_rdata,
  output logic [CNT_W-1:0]     dly_set,
  output logic [CNT_W-1:0]     wid_set
);
  logic [CNT_W-1:0] regs_q [TGG_NREG];

  for (genvar g = 0; g < TGG_NREG; g++) begin : g_reg
    logic wr_en;
    assign wr_en = reg_wr && (reg_sel == TGG_SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     regs_q[g] <= '0;
      else if (wr_en) regs_q[g] <= reg_wdata;
    end
  end

  assign reg_rdata = regs_q[reg_sel];
  assign dly_set   = regs_q[TGG_SEL_DLY];
  assign wid_set   = regs_q[TGG_SEL_WID];
endmodule

// File: rtl/tgg_seq.sv
module tgg_seq
  import tgg_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned FIX_DLY = 9,
  parameter int unsigned FIX_WID = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_edge,
  input  logic             tick,
  input  logic [CNT_W-1:0] dly_set,
  input  logic [CNT_W-1:0] wid_set,
  output logic             accept,
  output logic             gate,
  output logic             busy
);
  localparam int unsigned RW = CNT_W + 2;

  tgg_state_e       state_q, state_d;
  logic [RW-1:0]    rem_q, rem_d;
  logic [CNT_W-1:0] wid_q, wid_d;
  logic             last_tick;
  logic             step_en;

  always_comb begin
    accept    = (state_q == ST_IDLE) && trig_edge;
    last_tick = tick && (rem_q == RW'(1));
    step_en   = accept || tick;
    state_d   = state_q;
    rem_d     = rem_q;
    wid_d     = wid_q;
    unique case (state_q)
      ST_IDLE: begin
        if (trig_edge) begin
          state_d = ST_DELAY;
          rem_d   = RW'(FIX_DLY) + RW'(dly_set);
          wid_d   = wid_set;
        end
      end
      ST_DELAY: begin
        if (last_tick) begin
          state_d = ST_GATE;
          rem_d   = RW'(FIX_WID) + RW'(wid_q);
        end else if (tick) begin
          rem_d   = rem_q - RW'(1);
        end
      end
      ST_GATE: begin
        if (last_tick) begin
          state_d = ST_IDLE;
          rem_d   = '0;
        end else if (tick) begin
          rem_d   = rem_q - RW'(1);
        end
      end
      default: begin
        state_d = ST_IDLE;
        rem_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      wid_q   <= '0;
    end else if (step_en) begin
      state_q <= state_d;
      rem_q   <= rem_d;
      wid_q   <= wid_d;
    end
  end

  assign gate = (state_q == ST_GATE);
  assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/trig_gate_gen.sv
module trig_gate_gen
  import tgg_pkg::*;
#(
  parameter int unsigned TICK_CLKS   = 100,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned FIX_DLY     = 9,
  parameter int unsigned FIX_WID     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_in,
  input  logic             trig_inv,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             gate,
  output logic             busy
);
  logic             trig_edge;
  logic             tick;
  logic             accept;
  logic [CNT_W-1:0] dly_set;
  logic [CNT_W-1:0] wid_set;

  tgg_trig_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_inv(trig_inv),
    .trig_edge(trig_edge)
  );

  tgg_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dly_set(dly_set), .wid_set(wid_set)
  );

  tgg_prescaler #(.TICK_CLKS(TICK_CLKS)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(accept), .run(busy), .tick(tick)
  );

  tgg_seq #(.CNT_W(CNT_W), .FIX_DLY(FIX_DLY), .FIX_WID(FIX_WID)) u_seq (
    .clk(clk), .rst_n(rst_n), .trig_edge(trig_edge), .tick(tick),
    .dly_set(dly_set), .wid_set(wid_set), .accept(accept),
    .gate(gate), .busy(busy)
  );
endmodule

// File: rtl/tgg_checker.sv
module tgg_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_edge,
  input logic             reg_wr,
  input logic             reg_sel,
  input logic [CNT_W-1:0] reg_wdata,
  input logic [CNT_W-1:0] reg_rdata,
  input logic             gate,
  input logic             busy
);
  // R5: gate only inside a busy interval
  p_gate_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> busy);

  // R5: busy ends together with the gate
  p_fall_together_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate) |-> $fell(busy));

  // R5: minimum width of the gate spans more than one cycle
  p_gate_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |=> gate);

  // R4: gate rises only after a delay phase already under way
  p_gate_after_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> $past(busy));

  // R3: a cycle starts only from a detected trigger edge
  p_busy_from_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(trig_edge));

  // R2: a write is visible on read-back the next cycle
  p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_wr) && (reg_sel == $past(reg_sel))) |-> (reg_rdata == $past(reg_wdata)));
endmodule

bind trig_gate_gen tgg_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_edge(trig_edge), .reg_wr(reg_wr),
  .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .gate(gate), .busy(busy)
);

// File: tb/sim_trig_gate_gen.sv
module sim_trig_gate_gen;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS      = 3;
  localparam int FDLY       = 9;
  localparam int FWID       = 2;
  localparam int LIMIT      = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        trig_in;
  logic        trig_inv;
  logic        reg_wr;
  logic        reg_sel;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        gate;
  logic        busy;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_gate_gen #(.TICK_CLKS(TICKS)) u0 (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_inv(trig_inv),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .gate(gate), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit inv);
    rst_n = 1'b0; trig_inv = inv; trig_in = inv;
    reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input bit sel, input int val);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = 16'(val);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input bit sel, output int val);
    reg_sel = sel;
    #1;
    val = int'(reg_rdata);
  endtask

  task automatic cnt_gate(input bit want, output int n);
    n = 0;
    while (gate !== want && n < LIMIT) begin
      @(negedge clk);
      n++;
    end
  endtask

  // trigger must already be driven active; checks R3 latency
  task automatic see_accept(input string req);
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      chk(busy == (k == 3), req, busy, k == 3);
    end
  endtask

  task automatic full_run(input int d, input int w);
    int n, m, v;
    wr(1'b0, d);
    wr(1'b1, w);
    rd(1'b0, v); chk(v == d, "R2 delay readback", v, d);
    rd(1'b1, v); chk(v == w, "R2 width readback", v, w);
    trig_in = ~trig_inv;
    see_accept("R3 latency / R6 active edge");
    cnt_gate(1'b1, n);
    chk(n == (FDLY + d) * TICKS, "R4 delay", n, (FDLY + d) * TICKS);
    cnt_gate(1'b0, m);
    chk(m == (FWID + w) * TICKS, "R5 width", m, (FWID + w) * TICKS);
    chk(busy == 1'b0, "R5 busy falls with gate", busy, 0);
    repeat (6) @(negedge clk);
    chk(busy == 1'b0, "R9 held level no retrigger", busy, 0);
    trig_in = trig_inv;
    repeat (8) @(negedge clk);
    chk(busy == 1'b0, "R6 opposite edge ignored", busy, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int n, m, v;
    do_reset(1'b0);
    // R1: reset state
    chk(gate == 1'b0, "R1 gate", gate, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    rd(1'b0, v); chk(v == 0, "R1 delay reg", v, 0);
    rd(1'b1, v); chk(v == 0, "R1 width reg", v, 0);

    // sweep both polarities over small settings (R2..R6, R9)
    for (int inv = 0; inv < 2; inv++) begin
      do_reset(inv[0]);
      for (int d = 0; d < 6; d++)
        for (int w = 0; w < 4; w++)
          full_run(d, w);
    end

    // larger settings
    do_reset(1'b0);
    full_run(300, 500);

    // R7: second edge during the delay is ignored
    wr(1'b0, 2); wr(1'b1, 1);
    trig_in = 1'b1;
    see_accept("R7 first accept");
    repeat (2) @(negedge clk);
    trig_in = 1'b0;
    repeat (3) @(negedge clk);
    trig_in = 1'b1;
    n = 5;
    cnt_gate(1'b1, m); n += m;
    chk(n == (FDLY + 2) * TICKS, "R7 delay unchanged", n, (FDLY + 2) * TICKS);
    trig_in = 1'b0;
    repeat (2) @(negedge clk);
    trig_in = 1'b1;
    n = 2;
    cnt_gate(1'b0, m); n += m;
    chk(n == (FWID + 1) * TICKS, "R7 width unchanged", n, (FWID + 1) * TICKS);
    repeat (30) @(negedge clk);
    chk(busy == 1'b0, "R7 no later cycle", busy, 0);
    trig_in = 1'b0;
    repeat (5) @(negedge clk);

    // R8: writes during a cycle apply from the next trigger
    wr(1'b0, 4); wr(1'b1, 2);
    trig_in = 1'b1;
    see_accept("R8 accept");
    wr(1'b0, 1); wr(1'b1, 0);
    rd(1'b0, v); chk(v == 1, "R8 readback new delay", v, 1);
    n = 2;
    cnt_gate(1'b1, m); n += m;
    chk(n == (FDLY + 4) * TICKS, "R8 old delay used", n, (FDLY + 4) * TICKS);
    cnt_gate(1'b0, m);
    chk(m == (FWID + 2) * TICKS, "R8 old width used", m, (FWID + 2) * TICKS);
    trig_in = 1'b0;
    repeat (5) @(negedge clk);
    trig_in = 1'b1;
    see_accept("R8 second accept");
    cnt_gate(1'b1, n);
    chk(n == (FDLY + 1) * TICKS, "R8 new delay", n, (FDLY + 1) * TICKS);
    cnt_gate(1'b0, m);
    chk(m == FWID * TICKS, "R8 new width", m, FWID * TICKS);
    trig_in = 1'b0;
    repeat (5) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule